// File: doc/BRIEF.md
# Clock Source Status Register with Sticky Edge Flags

This block is a 16-bit memory-mapped status register for two clock sources: the system PLL lock indication and the high-frequency crystal stable indication. Each input arrives asynchronously. It passes through a synchronizer and then appears as a live, read-only bit. Every rising and every falling transition of each input is captured in its own sticky event flag.

Software reads the register to learn the current state of each source and which transitions have occurred. It acknowledges an event by writing 1 to that flag. An interrupt request is raised while any flag is set whose enable input is high. The register comes out of reset as though the PLL has already locked and the crystal is not yet stable, so it reads 0x0003.

Top module: `clkstat_reg`

## Requirements
- R1: After reset the register reads 0x0003 and `irq` is low. Leaving reset with the inputs at PLL high and crystal low creates no further event.
- R2: A read address equal to `REG_ADDR` (default 0x18) puts the register value on `rdata` one clock later. Any other address gives 0.
- R3: Bit 0 is the synchronized PLL lock level and bit 12 is the synchronized crystal stable level. Each passes through two synchronizer flops, so a change appears on `rdata` at the third clock edge after the input changes. Writes to bits 0 and 12 have no effect.
- R4: Bit 1 sets on a rising edge of the synchronized PLL lock. Bit 2 sets on a falling edge of it. Bit 1 becomes readable one clock after bit 0 shows the new level.
- R5: Bit 13 sets on a rising edge of the synchronized crystal stable input. Bit 14 sets on a falling edge of it.
- R6: A write of 1 to an event bit at `REG_ADDR` clears that bit. Writing 0 leaves it unchanged. A write to any other address changes nothing.
- R7: A cleared event bit stays clear until a new edge of the matching direction occurs.
- R8: If an edge sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: `irq` is high one clock after any flag is set whose enable is high. The enable mapping is `irq_en[0]`=bit 1, `irq_en[1]`=bit 2, `irq_en[2]`=bit 13 and `irq_en[3]`=bit 14.
- R10: Bits 15 and 11 to 3 always read 0, including after a write of 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data (1 clears an event bit) |
| rdata | output | DATA_W | Registered read data |
| pll_lock_in | input | 1 | Asynchronous PLL lock level |
| xtal_ok_in | input | 1 | Asynchronous crystal stable level |
| irq_en | input | 4 | Per-event interrupt enables |
| irq | output | 1 | Registered interrupt request |

## Verification
The PLL input is driven through a full loss-and-regain cycle and the crystal input through a full rise-and-fall cycle. This shows that each direction lands in its own flag and never in its neighbour's. Clears are tried as single-bit writes, as a write of 0xFFFF, as a write of 0, as writes to the live bits and as a write to the wrong address, which separates a true write-1-to-clear from a plain overwrite. The enables are stepped one at a time to show that each one routes only its own flag to the interrupt. Directed cases then place a falling PLL edge in the same cycle as a clear of that flag, sample the live bit and the event bit cycle by cycle, and reset the block in the middle of a run.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;

  localparam int NUM_SRC  = 2;
  localparam int SRC_PLL  = 0;
  localparam int SRC_XTAL = 1;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;

  typedef struct packed {
    logic live;
    logic rise;
    logic fall;
  } src_stat_t;

  // Bit position of the live level of a source; event bits follow it.
  function automatic int live_bit(input int src);
    return (src == SRC_PLL) ? 0 : 12;
  endfunction

  function automatic int rise_bit(input int src);
    return live_bit(src) + 1;
  endfunction

  function automatic int fall_bit(input int src);
    return live_bit(src) + 2;
  endfunction

  // Level assumed for a source while in reset.
  function automatic logic reset_level(input int src);
    return (src == SRC_PLL) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/clkstat_sync.sv
module clkstat_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkstat_flag.sv
module clkstat_flag
  import clkstat_pkg::*;
#(
  parameter edge_kind_e KIND    = EDGE_RISE,
  parameter logic       RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic prev,
  input  logic clr,
  output logic flag
);
  logic edge_hit;
  logic flag_q;

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign edge_hit = level & ~prev;
    end else begin : g_fall
      assign edge_hit = ~level & prev;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= RST_VAL;
    else if (edge_hit) flag_q <= 1'b1;
    else if (clr)      flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R4 / R5: an edge leaves the flag set
  a_r4_set_on_edge: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> flag_q);

  // R8: set wins over a simultaneous clear
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && clr) |=> flag_q);

  // R6: clear without an edge empties the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !edge_hit) |=> !flag_q);

  // R7: a clear flag stays clear without a new edge
  a_r7_stay_clear: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !edge_hit) |=> !flag_q);
endmodule

// File: rtl/clkstat_src.sv
module clkstat_src
  import clkstat_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_LEVEL   = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      async_in,
  input  logic      clr_rise,
  input  logic      clr_fall,
  output src_stat_t stat
);
  logic level;
  logic prev_q;
  logic [1:0] clr_vec;
  logic [1:0] flag_vec;

  clkstat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_LEVEL)) u_sync (
    .clk(clk), .rst(rst), .d(async_in), .q(level)
  );

  // History starts at the reset level so no edge is seen on leaving reset.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_LEVEL;
    else     prev_q <= level;
  end

  assign clr_vec = {clr_fall, clr_rise};

  generate
    for (genvar k = 0; k < 2; k++) begin : g_flag
      localparam edge_kind_e KIND = (k == 0) ? EDGE_RISE : EDGE_FALL;
      localparam logic       RVAL = (k == 0) ? RST_LEVEL : 1'b0;
      clkstat_flag #(.KIND(KIND), .RST_VAL(RVAL)) u_flag (
        .clk(clk), .rst(rst), .level(level), .prev(prev_q),
        .clr(clr_vec[k]), .flag(flag_vec[k])
      );
    end
  endgenerate

  assign stat.live = level;
  assign stat.rise = flag_vec[0];
  assign stat.fall = flag_vec[1];

  // R1: first cycle after reset sees no edge
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (level == prev_q));
endmodule

// File: rtl/clkstat_reg.sv
module clkstat_reg
  import clkstat_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h18,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pll_lock_in,
  input  logic              xtal_ok_in,
  input  logic [3:0]        irq_en,
  output logic              irq
);
  localparam int NUM_EVT = 2 * NUM_SRC;

  logic                hit;
  logic                wr_hit;
  logic [NUM_SRC-1:0]  async_vec;
  src_stat_t           stat [NUM_SRC];
  logic [NUM_EVT-1:0]  events;
  logic [DATA_W-1:0]   word;
  logic [DATA_W-1:0]   rdata_q;
  logic                irq_q;

  assign hit       = (addr == REG_ADDR);
  assign wr_hit    = hit & wr_en;
  assign async_vec = {xtal_ok_in, pll_lock_in};

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      clkstat_src #(
        .SYNC_STAGES(SYNC_STAGES),
        .RST_LEVEL  (reset_level(s))
      ) u_src (
        .clk     (clk),
        .rst     (rst),
        .async_in(async_vec[s]),
        .clr_rise(wr_hit & wdata[rise_bit(s)]),
        .clr_fall(wr_hit & wdata[fall_bit(s)]),
        .stat    (stat[s])
      );
      assign events[2*s]   = stat[s].rise;
      assign events[2*s+1] = stat[s].fall;
    end
  endgenerate

  always_comb begin
    word = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      word[live_bit(s)] = stat[s].live;
      word[rise_bit(s)] = stat[s].rise;
      word[fall_bit(s)] = stat[s].fall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= hit ? word : '0;
      irq_q   <= |(events & irq_en);
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

  // R9: an enabled flag raises irq on the next clock
  a_r9_irq_on: assert property (@(posedge clk) disable iff (rst)
    (|(events & irq_en)) |=> irq);

  // R9: no enabled flag means irq low on the next clock
  a_r9_irq_off: assert property (@(posedge clk) disable iff (rst)
    !(|(events & irq_en)) |=> !irq);
endmodule

// File: tb/test_clkstat_reg.sv
module test_clkstat_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h18;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pll_lock_in = 1'b1;
  logic        xtal_ok_in  = 1'b0;
  logic [3:0]  irq_en = '0;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  clkstat_reg i_clkstat_reg (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pll_lock_in(pll_lock_in), .xtal_ok_in(xtal_ok_in),
    .irq_en(irq_en), .irq(irq)
  );

  // {pll, xtal, wr, wdata[15:0], en[3:0], exp_rdata[15:0], exp_irq}
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 16'h0000, 4'h0, 16'h0003, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'h0000, 4'h1, 16'h0003, 1'b1},
    {1'b1, 1'b0, 1'b1, 16'h0002, 4'h1, 16'h0001, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'h1001, 4'h1, 16'h0001, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h0000, 4'h1, 16'h0004, 1'b0},
    {1'b0, 1'b0, 1'b0, 16'h0000, 4'h2, 16'h0004, 1'b1},
    {1'b1, 1'b0, 1'b0, 16'h0000, 4'h2, 16'h0007, 1'b1},
    {1'b1, 1'b0, 1'b1, 16'h0004, 4'h2, 16'h0003, 1'b0},
    {1'b1, 1'b1, 1'b0, 16'h0000, 4'h4, 16'h3003, 1'b1},
    {1'b1, 1'b1, 1'b1, 16'hFFFF, 4'h4, 16'h1001, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'h0000, 4'h8, 16'h4001, 1'b1},
    {1'b1, 1'b0, 1'b1, 16'h4000, 4'h8, 16'h0001, 1'b0},
    {1'b1, 1'b0, 1'b1, 16'h0000, 4'hF, 16'h0001, 1'b0},
    {1'b1, 1'b0, 1'b0, 16'h0000, 4'h0, 16'h0001, 1'b0}
  };
  localparam string VREQ [NV] = '{
    "R1", "R9", "R6", "R3", "R4", "R9", "R4",
    "R6", "R5", "R10", "R5", "R6", "R6", "R7"
  };

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    ticks(1);
    wr_en = 1'b0; wdata = '0; addr = 8'h18;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    ticks(4);
    rst = 1'b0;
    ticks(3);
    check("R1", rdata, 16'h0003);
    check("R1", {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      pll_lock_in = VEC[i][39];
      xtal_ok_in  = VEC[i][38];
      irq_en      = VEC[i][20:17];
      if (VEC[i][37]) reg_write(8'h18, VEC[i][36:21]);
      ticks(6);
      check(VREQ[i], rdata, VEC[i][16:1]);
      check(VREQ[i], {15'd0, irq}, {15'd0, VEC[i][0]});
    end

    // R8: falling PLL edge lands in the same cycle as a clear of bit 2
    pll_lock_in = 1'b0;
    ticks(2);
    reg_write(8'h18, 16'h0004);
    ticks(6);
    check("R8", rdata, 16'h0004);

    // R6: write to another address clears nothing; R2: other address reads 0
    reg_write(8'h20, 16'hFFFF);
    ticks(3);
    check("R6", rdata, 16'h0004);
    addr = 8'h20;
    ticks(1);
    check("R2", rdata, 16'h0000);
    addr = 8'h18;
    ticks(1);
    check("R2", rdata, 16'h0004);

    // R7: clear, then stay clear while the input is steady
    reg_write(8'h18, 16'h0004);
    ticks(20);
    check("R7", rdata, 16'h0000);

    // R3 / R4: cycle timing of the live bit and the lock event
    pll_lock_in = 1'b1;
    ticks(2);
    check("R3", rdata, 16'h0000);
    ticks(1);
    check("R3", rdata, 16'h0001);
    ticks(1);
    check("R4", rdata, 16'h0003);

    // R9: irq follows the enable one clock later
    irq_en = 4'h1;
    ticks(1);
    check("R9", {15'd0, irq}, 16'h0001);
    irq_en = 4'h0;
    ticks(1);
    check("R9", {15'd0, irq}, 16'h0000);

    // R1: reset in the middle of a run with flags set
    xtal_ok_in = 1'b1;
    ticks(6);
    xtal_ok_in = 1'b0;
    ticks(6);
    check("R5", rdata, 16'h6003);
    rst = 1'b1;
    ticks(3);
    rst = 1'b0;
    ticks(6);
    check("R1", rdata, 16'h0003);
    check("R1", {15'd0, irq}, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule